// File: doc/BRIEF.md
# Event and Cycle Performance Monitor

This block counts processor activity for profiling. It has one 32-bit cycle counter and two 32-bit event counters. Each event counter watches one line of a 256-wide vector of one-cycle event pulses. An 8-bit event code picks that line. The control word holds the run enable, the one-shot counter resets, a divide-by-64 option for the cycle counter, three interrupt enables, three overflow flags and both event codes.

Software reaches the control word and the three counters through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the current register state. When a counter wraps from all ones to zero, its flag sets. A flag whose interrupt enable is also set raises the level interrupt `irq`. Software clears a flag by writing 1 to it. The usual pattern is to load a counter with a value close to all ones, so that the wrap arrives after a chosen number of events.

Top module: `evmon_top`

## Requirements
- R1: While control bit 0 (run) is 0, no counter advances; only direct writes and the one-shot resets change them.
- R2: A control write with bit 1 set zeroes both event counters, and one with bit 2 set zeroes the cycle counter and its divider. Neither bit is stored, and both read back as 0.
- R3: With control bit 3 set, the cycle counter advances once per 64 clocks during which run is set. The divider restarts from zero on a cycle reset. With bit 3 clear, the cycle counter advances on every clock during which run is set.
- R4: Event counter 0 takes its code from control bits 19:12, and event counter 1 from bits 27:20. With run set, a counter advances by one on each clock in which the pulse-vector bit at its code is high. Code 0xFF never advances it. Example codes are 0x07 (instruction executed) and 0x05 (branch).
- R5: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag. Bit 8 is the flag for event counter 0, bit 9 for event counter 1 and bit 10 for the cycle counter.
- R6: Writing 1 to a flag bit in a control write clears that flag, and writing 0 leaves it unchanged. If a clear and a new wrap of the same counter fall in the same cycle, the flag stays set.
- R7: `irq` is high exactly when some flag is set together with its enable. Bit 4 enables event counter 0, bit 5 enables event counter 1 and bit 6 enables the cycle counter.
- R8: Control bits 7, 11 and 31:28 ignore writes and read as 0.
- R9: Address 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. Each counter reads back its value and loads the written value. A load overrides an increment in the same cycle.
- R10: Control bits 0, 3, 6:4 and 27:12 read back the value last written, and all registers are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| ev_pulse | input | 256 | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a flag clear and a fresh wrap of the same counter in one cycle. It needs the counter at all ones, run set and the selected pulse present, all in the same cycle as a control write that carries both the clear bit and unchanged fields. A directed sequence preloads event counter 1 with 0xFFFFFFFF and issues that write together with the pulse. Random phases then reload counters a few steps below the wrap, under random enables, codes, resets and flag clears. This makes wraps, clears and divider ticks overlap often. A cycle-level bench model predicts every read and `irq`.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int DATA_W  = 32;
  localparam int NCNT    = 3;
  // Counter index order matches flag and enable bit order.
  localparam int CNT_EV0 = 0;
  localparam int CNT_EV1 = 1;
  localparam int CNT_CYC = 2;
  // Control word bit positions.
  localparam int B_RUN   = 0;
  localparam int B_EVRST = 1;
  localparam int B_CYRST = 2;
  localparam int B_DIV   = 3;
  localparam int B_IEN   = 4;
  localparam int B_FLG   = 8;
  localparam int B_SEL0  = 12;
  localparam int B_SEL1  = 20;

  function automatic logic [1:0] addr_of(input int idx);
    case (idx)
      CNT_EV0: addr_of = 2'd2;
      CNT_EV1: addr_of = 2'd3;
      default: addr_of = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/evmon_rst_sync.sv
module evmon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/evmon_div.sv
module evmon_div #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == {DIV_LOG2{1'b1}});
endmodule

// File: rtl/evmon_cnt.sv
module evmon_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         wrap
);
  logic [W-1:0] val_d;

  // Load beats reset, reset beats increment.
  always_comb begin
    val_d = val;
    if (load)     val_d = ldata;
    else if (clr) val_d = '0;
    else if (inc) val_d = val + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else        val <= val_d;
  end

  assign wrap = inc && !load && !clr && (&val);
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
#(
  parameter int EV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCNT-1:0]   wrap,
  output logic              run_q,
  output logic              div_q,
  output logic [NCNT-1:0]   ien_q,
  output logic [NCNT-1:0]   flag_q,
  output logic [EV_W-1:0]   sel0_q,
  output logic [EV_W-1:0]   sel1_q,
  output logic [DATA_W-1:0] ctrl_rd
);
  logic            run_d, div_d;
  logic [NCNT-1:0] ien_d, flag_d, flag_clr;
  logic [EV_W-1:0] sel0_d, sel1_d;
  logic            unused_bits;

  assign unused_bits = ^{wdata[31:28], wdata[11], wdata[7], wdata[2:1]};
  assign flag_clr    = wr_ctrl ? wdata[B_FLG +: NCNT] : '0;

  always_comb begin
    run_d  = run_q;
    div_d  = div_q;
    ien_d  = ien_q;
    sel0_d = sel0_q;
    sel1_d = sel1_q;
    // A new wrap takes priority over a clear in the same cycle.
    flag_d = (flag_q & ~flag_clr) | wrap;
    if (wr_ctrl) begin
      run_d  = wdata[B_RUN];
      div_d  = wdata[B_DIV];
      ien_d  = wdata[B_IEN +: NCNT];
      sel0_d = wdata[B_SEL0 +: EV_W];
      sel1_d = wdata[B_SEL1 +: EV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= 1'b0;
      ien_q  <= '0;
      flag_q <= '0;
      sel0_q <= '0;
      sel1_q <= '0;
    end else begin
      run_q  <= run_d;
      div_q  <= div_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
      sel0_q <= sel0_d;
      sel1_q <= sel1_d;
    end
  end

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[B_RUN]              = run_q;
    ctrl_rd[B_DIV]              = div_q;
    ctrl_rd[B_IEN +: NCNT]      = ien_q;
    ctrl_rd[B_FLG +: NCNT]      = flag_q;
    ctrl_rd[B_SEL0 +: EV_W]     = sel0_q;
    ctrl_rd[B_SEL1 +: EV_W]     = sel1_q;
  end
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int EV_W     = 8,
  parameter int DIV_LOG2 = 6,
  localparam int NEV     = 1 << EV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NEV-1:0]    ev_pulse,
  output logic              irq
);
  logic              rst_sn;
  logic              wr_ctrl;
  logic              run_q, div_q, div_tick;
  logic [NCNT-1:0]   ien_q, flag_q, inc, wrap, clr;
  logic [EV_W-1:0]   sel0_q, sel1_q;
  logic [EV_W-1:0]   sel [2];
  logic [DATA_W-1:0] ctrl_rd;
  logic [CNT_W-1:0]  cnt_val [NCNT];

  evmon_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign wr_ctrl = reg_wr && (reg_addr == 2'd0);

  evmon_ctrl #(.EV_W(EV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .wrap(wrap), .run_q(run_q), .div_q(div_q), .ien_q(ien_q),
    .flag_q(flag_q), .sel0_q(sel0_q), .sel1_q(sel1_q), .ctrl_rd(ctrl_rd)
  );

  evmon_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk), .rst_n(rst_sn), .run(run_q && div_q),
    .clr(clr[CNT_CYC]), .tick(div_tick)
  );

  assign sel[0] = sel0_q;
  assign sel[1] = sel1_q;

  // Event counter advance: run set, code not the unused code, pulse present.
  for (genvar e = 0; e < 2; e++) begin : g_ev_inc
    assign inc[e] = run_q && (sel[e] != {EV_W{1'b1}}) && ev_pulse[sel[e]];
    assign clr[e] = wr_ctrl && reg_wdata[B_EVRST];
  end
  assign inc[CNT_CYC] = run_q && (!div_q || div_tick);
  assign clr[CNT_CYC] = wr_ctrl && reg_wdata[B_CYRST];

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    evmon_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_sn),
      .load(reg_wr && (reg_addr == addr_of(k))),
      .ldata(reg_wdata[CNT_W-1:0]),
      .clr(clr[k]), .inc(inc[k]),
      .val(cnt_val[k]), .wrap(wrap[k])
    );
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl_rd;
      2'd1:    reg_rdata = DATA_W'(cnt_val[CNT_CYC]);
      2'd2:    reg_rdata = DATA_W'(cnt_val[CNT_EV0]);
      default: reg_rdata = DATA_W'(cnt_val[CNT_EV1]);
    endcase
  end

  assign irq = |(flag_q & ien_q);
endmodule

// File: rtl/evmon_chk.sv
module evmon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        irq,
  input logic        run_q,
  input logic [7:0]  sel0_q,
  input logic [2:0]  flag_q,
  input logic [2:0]  inc,
  input logic [2:0]  wrap,
  input logic [31:0] cyc_cnt,
  input logic [31:0] ev0_cnt,
  input logic [31:0] ev1_cnt
);
  assert_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_wr) |=> ($stable(cyc_cnt) && $stable(ev0_cnt) && $stable(ev1_cnt)));

  assert_ev_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[1]) |=> (ev0_cnt == 32'd0 && ev1_cnt == 32'd0));

  assert_unused_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && sel0_q == 8'hFF && !reg_wr) |=> $stable(ev0_cnt));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc[0] && ev0_cnt == 32'hFFFF_FFFF && !reg_wr) |=> (flag_q[0] && ev0_cnt == 32'd0));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && reg_wr && reg_addr == 2'd0 && reg_wdata[9] && !wrap[1]) |=> !flag_q[1]);

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (flag_q != 3'b000));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[31:28] == 4'd0 && !reg_rdata[11] && !reg_rdata[7] && reg_rdata[2:1] == 2'd0));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> (cyc_cnt == $past(reg_wdata)));
endmodule

bind evmon_top evmon_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .run_q(run_q),
  .sel0_q(sel0_q), .flag_q(flag_q), .inc(inc), .wrap(wrap),
  .cyc_cnt(cnt_val[2]), .ev0_cnt(cnt_val[0]), .ev1_cnt(cnt_val[1])
);

// File: tb/sim_evmon_top.sv
module sim_evmon_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [1:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [255:0] ev_pulse;
  logic         irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Bench model of the requirements.
  logic        m_run, m_div;
  logic [2:0]  m_ien, m_flg;
  logic [7:0]  m_sel0, m_sel1;
  logic [31:0] m_cnt [3];   // 0 event 0, 1 event 1, 2 cycle
  logic [5:0]  m_ps;

  evmon_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] m_ctrl();
    logic [31:0] v = '0;
    v[0] = m_run; v[3] = m_div; v[6:4] = m_ien; v[10:8] = m_flg;
    v[19:12] = m_sel0; v[27:20] = m_sel1;
    return v;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_ctrl();
      2'd1:    return m_cnt[2];
      2'd2:    return m_cnt[0];
      default: return m_cnt[1];
    endcase
  endfunction

  task automatic m_reset();
    m_run = 0; m_div = 0; m_ien = 0; m_flg = 0; m_sel0 = 0; m_sel1 = 0; m_ps = 0;
    for (int k = 0; k < 3; k++) m_cnt[k] = '0;
  endtask

  task automatic m_edge(input logic w, input logic [1:0] a, input logic [31:0] d, input logic [255:0] p);
    logic [2:0] inc, wrp, ld, cl;
    logic tick;
    logic wc;
    wc    = w && (a == 2'd0);
    tick  = m_run && m_div && (m_ps == 6'd63);
    inc[0] = m_run && (m_sel0 != 8'hFF) && p[m_sel0];
    inc[1] = m_run && (m_sel1 != 8'hFF) && p[m_sel1];
    inc[2] = m_run && (!m_div || tick);
    ld = {w && a == 2'd1, w && a == 2'd3, w && a == 2'd2};
    cl = {wc && d[2], wc && d[1], wc && d[1]};
    for (int k = 0; k < 3; k++) begin
      wrp[k] = inc[k] && !ld[k] && !cl[k] && (m_cnt[k] == 32'hFFFF_FFFF);
      if (ld[k])       m_cnt[k] = d;
      else if (cl[k])  m_cnt[k] = '0;
      else if (inc[k]) m_cnt[k] = m_cnt[k] + 1;
    end
    if (cl[2])                m_ps = '0;
    else if (m_run && m_div)  m_ps = m_ps + 1;
    m_flg = (m_flg & ~(wc ? d[10:8] : 3'b000)) | wrp;
    if (wc) begin
      m_run = d[0]; m_div = d[3]; m_ien = d[6:4]; m_sel0 = d[19:12]; m_sel1 = d[27:20];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d, input logic [255:0] p);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; ev_pulse = p;
    m_edge(w, a, d, p);
    @(posedge clk);
  endtask

  // Read check before the next edge, then an idle cycle.
  task automatic peek(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_wr = 0; reg_addr = a; reg_wdata = '0; ev_pulse = '0;
    #1;
    chk(req, reg_rdata, exp);
    chk("R7 irq", {31'd0, irq}, {31'd0, |(m_flg & m_ien)});
    m_edge(1'b0, a, 32'd0, '0);
    @(posedge clk);
  endtask

  function automatic logic [7:0] pick_code();
    case ($urandom % 6)
      0: return 8'h00;
      1: return 8'h05;
      2: return 8'h06;
      3: return 8'h07;
      4: return 8'h0B;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [255:0] rnd_pulses();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom & $urandom;
    return v;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] c;
    logic [255:0] p;
    void'($urandom(32'd20240611));
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; ev_pulse = 0;
    m_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);

    // Reset state (R10).
    for (int a = 0; a < 4; a++) peek("R10 reset value", 2'(a), 32'd0);

    // Field readback, reserved bits ignored (R10, R8).
    step(1, 2'd0, 32'h8070_5091, '0);
    peek("R10 field readback", 2'd0, 32'h0070_5011);
    step(1, 2'd0, 32'hFFFF_FFFF, '0);
    peek("R8 reserved read zero", 2'd0, 32'h0FFF_F079);

    // Load wins over increment (R9).
    step(1, 2'd0, 32'h0000_0001, '0);
    step(1, 2'd1, 32'h1234_0000, '0);
    peek("R9 load over increment", 2'd1, 32'h1234_0000);
    peek("R9 count after load", 2'd1, 32'h1234_0001);

    // Event counting and unused code (R4).
    step(1, 2'd0, 32'h0FF0_7003, '0);
    p = '0; p[7] = 1; p[255] = 1;
    repeat (3) step(0, 2'd0, 32'd0, p);
    peek("R4 event counter 0", 2'd2, 32'd3);
    peek("R4 unused code", 2'd3, 32'd0);

    // Freeze (R1).
    step(1, 2'd0, 32'h0FF0_7000, '0);
    c = m_cnt[2];
    repeat (4) step(0, 2'd0, 32'd0, '1);
    peek("R1 frozen event", 2'd2, 32'd3);
    peek("R1 frozen cycle", 2'd1, c);

    // One-shot resets (R2).
    step(1, 2'd0, 32'h0FF0_7002, '0);
    peek("R2 event reset", 2'd2, 32'd0);
    peek("R2 reset bits not stored", 2'd0, 32'h0FF0_7000);
    step(1, 2'd0, 32'h0000_0004, '0);
    peek("R2 cycle reset", 2'd1, 32'd0);

    // Prescale (R3).
    step(1, 2'd0, 32'h0000_000D, '0);
    repeat (127) step(0, 2'd0, 32'd0, '0);
    peek("R3 prescale first tick", 2'd1, 32'd1);
    peek("R3 prescale second tick", 2'd1, 32'd2);

    // Overflow, interrupt and flag clearing (R5, R6, R7).
    c = 32'h005F_F021;
    p = '0; p[5] = 1;
    step(1, 2'd0, c, '0);
    step(1, 2'd3, 32'hFFFF_FFFF, '0);
    step(0, 2'd0, 32'd0, p);
    peek("R5 wrapped to zero", 2'd3, 32'd0);
    peek("R5 flag bit 9 set", 2'd0, c | 32'h200);
    chk("R7 irq raised", {31'd0, irq}, 32'd1);
    step(1, 2'd0, c, '0);
    peek("R6 writing 0 keeps flag", 2'd0, c | 32'h200);
    step(1, 2'd0, c | 32'h200, '0);
    peek("R6 writing 1 clears flag", 2'd0, c);
    chk("R7 irq dropped", {31'd0, irq}, 32'd0);
    step(1, 2'd3, 32'hFFFF_FFFF, '0);
    step(1, 2'd0, c | 32'h200, p);
    peek("R6 clear with coincident wrap", 2'd0, c | 32'h200);
    step(1, 2'd0, c & ~32'h20, '0);
    peek("R7 flag without enable", 2'd0, (c & ~32'h20) | 32'h200);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);

    // Random phase against the model.
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [31:0] d;
      logic [1:0] a;
      op = $urandom % 16;
      a  = 2'($urandom % 4);
      if (op == 0) begin
        d = $urandom;
        d[0] = ($urandom % 4) != 0;
        d[3] = ($urandom % 6) == 0;
        d[1] = ($urandom % 10) == 0;
        d[2] = ($urandom % 10) == 0;
        d[19:12] = pick_code();
        d[27:20] = pick_code();
        step(1, 2'd0, d, rnd_pulses());
      end else if (op <= 2) begin
        step(1, (a == 2'd0) ? 2'd1 : a, 32'hFFFF_FFFF - ($urandom % 6), rnd_pulses());
      end else if (op <= 8) begin
        step(0, a, 32'd0, rnd_pulses());
      end else begin
        case (a)
          2'd0:    peek("R10 random control", a, m_read(a));
          2'd1:    peek("R3 random cycle", a, m_read(a));
          default: peek("R9 random event", a, m_read(a));
        endcase
      end
    end

    report();
  end
endmodule